// File: doc/BRIEF.md
# Receive Frame Queue

This block sits between the receive side of an Ethernet MAC and a host register port. The MAC delivers each frame as a run of 32-bit data beats. The final beat of a frame carries one 32-bit status word. The data words go into a data FIFO. The status word goes into its own, shallower status FIFO.

The host first reads the count word. Its upper half tells how many complete frames are waiting, and its lower half tells how many data words are readable. The host then pops one status word, takes the byte length from it, and pops ceil(length/4) data words. A frame is only visible once it is complete and both FIFOs have accepted it. A frame that cannot fit is discarded whole, so the host never sees a partial frame.

The block has three interrupt outputs:
- an almost-full level, raised when the number of queued frames rises above a programmable threshold;
- a sticky flag for a frame lost to a full status FIFO;
- a sticky flag for a frame lost to a full data FIFO.

A flush input, while held, empties both FIFOs.

Top module: `rxq_frame_queue`

## Requirements
- R1: After reset, `count_word` is 0, `stat_err` is 0 and all three interrupt outputs are 0.
- R2: Data words of a frame in progress are not counted. On the clock edge that takes the beat with `wr_last`, the frame count (`count_word[31:16]`) rises by one and the readable word count (`count_word[15:0]`) rises by the frame's word count.
- R3: `stat_word` shows the oldest waiting status word unchanged: byte length in bits 15:0, flags in bits 31:16. Status words leave in arrival order, one per `stat_pop`.
- R4: `data_word` shows the oldest readable data word. Each `data_pop` removes it and lowers `count_word[15:0]` by one. Data leaves in arrival order, so after a status pop the next ceil(length/4) pops return that frame's words.
- R5: `stat_err` is 1 exactly when a status word is waiting and that word ANDed with 32'hDF180000 is nonzero.
- R6: `irq_almost_full` is 1 exactly while the frame count is greater than `af_thresh`.
- R7: If a data beat arrives while the data FIFO, counting the current frame's own words, already holds DATA_DEPTH words, the whole frame is dropped. Its stored words are rolled back, frames queued earlier are untouched, and `irq_data_full` is set and stays set until a flush.
- R8: If the last beat of a frame arrives while the status FIFO holds STAT_DEPTH entries, the whole frame is dropped and rolled back, and `irq_stat_full` is set and stays set until a flush.
- R9: While `flush` is 1 at a clock edge, both FIFOs are emptied, the beat presented in that cycle is discarded, and both sticky flags are cleared, so `count_word` reads 0 on the next cycle.
- R10: `stat_pop` or `data_pop` with nothing readable has no effect on the queue.
- R11: After a dropped frame, the next frame is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A data beat from the MAC is present |
| wr_last | input | 1 | This beat ends the frame |
| wr_data | input | 32 | Data word of the beat |
| wr_status | input | 32 | Frame status word, taken on the last beat |
| flush | input | 1 | Empty both FIFOs while held |
| af_thresh | input | 16 | Almost-full threshold, in frames |
| stat_pop | input | 1 | Remove the oldest status word |
| stat_word | output | 32 | Oldest status word (0 when none) |
| stat_err | output | 1 | Oldest status word has an error bit set |
| data_pop | input | 1 | Remove the oldest data word |
| data_word | output | 32 | Oldest readable data word (0 when none) |
| count_word | output | 32 | {frames waiting, readable data words} |
| irq_almost_full | output | 1 | Frame count above threshold |
| irq_stat_full | output | 1 | Sticky: frame lost to a full status FIFO |
| irq_data_full | output | 1 | Sticky: frame lost to a full data FIFO |

## Verification
The bench sends frames of different word counts and byte lengths, including lengths that are not multiples of four and a status word with an error bit set. It also lets frames queue past the threshold, so it can show that frame and word counts, ordering, and the error summary follow each frame rather than each beat.

A frame that overflows the data FIFO in mid-frame is checked against an earlier frame left in the queue, to show that the rollback removes only the failing frame's words. A fifth frame into a full status FIFO exercises the other loss path. A flush with a beat arriving at the same time, and pops on an empty queue, complete the set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned RXQ_WORD_W = 32;
  localparam int unsigned RXQ_CNT_W  = 16;

  // status bits that flag a receive error
  localparam logic [RXQ_WORD_W-1:0] RXQ_ERR_MASK = 32'hDF18_0000;

  // per-frame admission state of the write side
  typedef enum logic {
    RXQ_PASS = 1'b0,
    RXQ_DROP = 1'b1
  } rxq_mode_e;

endpackage

// File: rtl/rxq_stat_fifo.sv
// Per-frame status FIFO. DEPTH must be a power of two.
module rxq_stat_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [PW-1:0]    count,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic do_push, do_pop, empty;

  assign count = wp_q - rp_q;
  assign full  = (count == PW'(DEPTH));
  assign empty = (count == '0);

  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_comb begin
    wp_n = wp_q;
    rp_n = rp_q;
    if (clr) begin
      wp_n = '0;
      rp_n = '0;
    end else begin
      if (do_push) wp_n = wp_q + PW'(1);
      if (do_pop)  rp_n = rp_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= push_data;
  end

  assign head = empty ? '0 : mem[rp_q[AW-1:0]];

  // R8: occupancy never exceeds the storage
  p_stat_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));

  // R10: a pop on an empty FIFO leaves it empty
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> (count == '0));

endmodule

// File: rtl/rxq_data_fifo.sv
// Data FIFO with a committed and a speculative write pointer.
// Words written since the last commit can be rolled back. DEPTH must be a power of two.
module rxq_data_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             commit,
  input  logic             rollback,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [PW-1:0]    fill,
  output logic             spec_full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] rp_q, rp_n, cp_q, cp_n, sp_q, sp_n, sp_adv;
  logic [PW-1:0] spec_fill;
  logic do_push, do_pop;

  assign fill      = cp_q - rp_q;
  assign spec_fill = sp_q - rp_q;
  assign spec_full = (spec_fill == PW'(DEPTH));

  assign do_push = push && !spec_full && !clr;
  assign do_pop  = pop && (fill != '0) && !clr;
  assign sp_adv  = do_push ? (sp_q + PW'(1)) : sp_q;

  always_comb begin
    rp_n = rp_q;
    cp_n = cp_q;
    sp_n = sp_adv;
    if (clr) begin
      rp_n = '0;
      cp_n = '0;
      sp_n = '0;
    end else begin
      if (do_pop) rp_n = rp_q + PW'(1);
      if (rollback) begin
        sp_n = cp_q;
      end else if (commit) begin
        cp_n = sp_adv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q <= '0;
      cp_q <= '0;
      sp_q <= '0;
    end else begin
      rp_q <= rp_n;
      cp_q <= cp_n;
      sp_q <= sp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[sp_q[AW-1:0]] <= push_data;
  end

  assign head = (fill == '0) ? '0 : mem[rp_q[AW-1:0]];

  // R7: speculative occupancy bounded by storage
  p_spec_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spec_fill <= PW'(DEPTH));

  // R2: uncommitted words never count as readable
  p_commit_behind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= spec_fill);

  // R7: a rollback leaves only committed words
  p_rollback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback && !clr) |=> (spec_fill == fill));

endmodule

// File: rtl/rxq_irq.sv
// Threshold compare and sticky loss flags.
module rxq_irq #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] frames,
  input  logic [CNT_W-1:0] thresh,
  input  logic             set_stat_full,
  input  logic             set_data_full,
  output logic             almost_full,
  output logic             stat_full_flag,
  output logic             data_full_flag
);

  logic sf_q, sf_n, df_q, df_n;

  assign almost_full = (frames > thresh);

  always_comb begin
    sf_n = sf_q;
    df_n = df_q;
    if (clr) begin
      sf_n = 1'b0;
      df_n = 1'b0;
    end else begin
      if (set_stat_full) sf_n = 1'b1;
      if (set_data_full) df_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q <= 1'b0;
      df_q <= 1'b0;
    end else begin
      sf_q <= sf_n;
      df_q <= df_n;
    end
  end

  assign stat_full_flag = sf_q;
  assign data_full_flag = df_q;

  // R7: data-full flag is held until cleared
  p_data_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (df_q && !clr) |=> df_q);

  // R8: status-full flag is held until cleared
  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_q && !clr) |=> sf_q);

  // R9: clearing drops both flags
  p_clear_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!sf_q && !df_q));

endmodule

// File: rtl/rxq_frame_queue.sv
module rxq_frame_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_DEPTH = 16,
  parameter int unsigned STAT_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic                  wr_last,
  input  logic [RXQ_WORD_W-1:0] wr_data,
  input  logic [RXQ_WORD_W-1:0] wr_status,
  input  logic                  flush,
  input  logic [RXQ_CNT_W-1:0]  af_thresh,
  input  logic                  stat_pop,
  output logic [RXQ_WORD_W-1:0] stat_word,
  output logic                  stat_err,
  input  logic                  data_pop,
  output logic [RXQ_WORD_W-1:0] data_word,
  output logic [RXQ_WORD_W-1:0] count_word,
  output logic                  irq_almost_full,
  output logic                  irq_stat_full,
  output logic                  irq_data_full
);

  localparam int unsigned DPW = $clog2(DATA_DEPTH) + 1;
  localparam int unsigned SPW = $clog2(STAT_DEPTH) + 1;

  rxq_mode_e mode_q, mode_n;

  logic beat, frame_end, ovf_now, bad_frame;
  logic d_push, d_commit, d_rollback, d_spec_full;
  logic [DPW-1:0] d_fill;
  logic [SPW-1:0] s_count;
  logic s_full;
  logic [RXQ_CNT_W-1:0] frames;

  // ---- write-side admission ----
  assign beat      = wr_valid && !flush;
  assign frame_end = beat && wr_last;
  assign ovf_now   = beat && (mode_q == RXQ_PASS) && d_spec_full;
  assign d_push    = beat && (mode_q == RXQ_PASS) && !d_spec_full;
  assign bad_frame = (mode_q == RXQ_DROP) || ovf_now || s_full;
  assign d_commit   = frame_end && !bad_frame;
  assign d_rollback = frame_end && bad_frame;

  always_comb begin
    mode_n = mode_q;
    if (flush || frame_end) begin
      mode_n = RXQ_PASS;
    end else if (ovf_now) begin
      mode_n = RXQ_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RXQ_PASS;
    else        mode_q <= mode_n;
  end

  // ---- storage ----
  rxq_data_fifo #(.DEPTH(DATA_DEPTH), .WIDTH(RXQ_WORD_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush),
    .push      (d_push),
    .push_data (wr_data),
    .commit    (d_commit),
    .rollback  (d_rollback),
    .pop       (data_pop),
    .head      (data_word),
    .fill      (d_fill),
    .spec_full (d_spec_full)
  );

  rxq_stat_fifo #(.DEPTH(STAT_DEPTH), .WIDTH(RXQ_WORD_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush),
    .push      (d_commit),
    .push_data (wr_status),
    .pop       (stat_pop),
    .head      (stat_word),
    .count     (s_count),
    .full      (s_full)
  );

  assign frames     = RXQ_CNT_W'(s_count);
  assign count_word = {frames, RXQ_CNT_W'(d_fill)};
  assign stat_err   = (s_count != '0) && ((stat_word & RXQ_ERR_MASK) != '0);

  // ---- interrupts ----
  rxq_irq #(.CNT_W(RXQ_CNT_W)) u_irq (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (flush),
    .frames         (frames),
    .thresh         (af_thresh),
    .set_stat_full  (frame_end && s_full),
    .set_data_full  (ovf_now),
    .almost_full    (irq_almost_full),
    .stat_full_flag (irq_stat_full),
    .data_full_flag (irq_data_full)
  );

  // R9: flush leaves both FIFOs empty on the next cycle
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_word == '0));

  // R2: at most one frame becomes visible per cycle
  p_frame_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frames <= $past(frames) + RXQ_CNT_W'(1));

  // R5: error summary only with a waiting frame
  p_err_needs_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err |-> (frames != '0));

  // R8: status-full flag rises only after a frame end
  p_stat_full_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat_full) |-> $past(wr_valid && wr_last));

endmodule

// File: tb/tb_rxq_frame_queue.sv
module tb_rxq_frame_queue;

  localparam logic [31:0] ERR_MASK = 32'hDF18_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid, wr_last, flush, stat_pop, data_pop;
  logic [31:0] wr_data, wr_status, stat_word, data_word, count_word;
  logic [15:0] af_thresh;
  logic stat_err, irq_almost_full, irq_stat_full, irq_data_full;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] exp_stat[$];
  logic [31:0] exp_data[$];

  always #10 clk = ~clk;

  rxq_frame_queue #(.DATA_DEPTH(16), .STAT_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
    .wr_data(wr_data), .wr_status(wr_status), .flush(flush),
    .af_thresh(af_thresh), .stat_pop(stat_pop), .stat_word(stat_word),
    .stat_err(stat_err), .data_pop(data_pop), .data_word(data_word),
    .count_word(count_word), .irq_almost_full(irq_almost_full),
    .irq_stat_full(irq_stat_full), .irq_data_full(irq_data_full)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_cnt(input string req, input int frames, input int words);
    logic [31:0] e;
    e = {16'(frames), 16'(words)};
    check(count_word == e, req, count_word, e);
  endtask

  // driver: sends a frame, records expectations when it should be kept
  task automatic send_frame(input int n, input logic [31:0] st, input bit keep,
                            input int tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid  = 1'b1;
      wr_last   = (i == n - 1);
      wr_data   = {8'(tag), 16'h0, 8'(i)};
      wr_status = st;
      if (keep) exp_data.push_back(wr_data);
    end
    if (keep) exp_stat.push_back(st);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  // monitor: pops one frame and compares against the scoreboard
  task automatic drain_frame(input string req);
    logic [31:0] st, d;
    int nw;
    st = exp_stat.pop_front();
    check(stat_word == st, {req, " status"}, stat_word, st);
    check(stat_err == ((st & ERR_MASK) != 0), "R5 error summary",
          32'(stat_err), 32'((st & ERR_MASK) != 0));
    stat_pop = 1'b1;
    @(negedge clk);
    stat_pop = 1'b0;
    nw = (int'(st[15:0]) + 3) / 4;
    for (int i = 0; i < nw; i++) begin
      d = exp_data.pop_front();
      check(data_word == d, {req, " data"}, data_word, d);
      data_pop = 1'b1;
      @(negedge clk);
      data_pop = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_last = 1'b0; wr_data = '0; wr_status = '0;
    flush = 1'b0; stat_pop = 1'b0; data_pop = 1'b0; af_thresh = 16'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_cnt("R1 count", 0, 0);
    check({stat_err, irq_almost_full, irq_stat_full, irq_data_full} == 4'b0,
          "R1 flags", 32'({stat_err, irq_almost_full, irq_stat_full, irq_data_full}), 0);

    // R2 partial frame invisible, then visible on the last beat
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (i == 2) check_cnt("R2 mid-frame", 0, 0);
      wr_valid = 1'b1; wr_last = (i == 2);
      wr_data = {8'hA1, 16'h0, 8'(i)}; wr_status = 32'd10;
      exp_data.push_back(wr_data);
    end
    exp_stat.push_back(32'd10);
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    check_cnt("R2 frame done", 1, 3);
    check(irq_almost_full == 1'b0, "R6 at threshold", 32'(irq_almost_full), 0);

    // second frame with an error bit; length 5 -> 2 words
    send_frame(2, 32'h0008_0005, 1'b1, 8'hB2);
    check_cnt("R2 two frames", 2, 5);
    check(irq_almost_full == 1'b1, "R6 above threshold", 32'(irq_almost_full), 1);

    drain_frame("R3 R4 frame A");
    check(irq_almost_full == 1'b0, "R6 back at threshold", 32'(irq_almost_full), 0);
    check_cnt("R4 after frame A", 1, 2);
    drain_frame("R3 R4 frame B");
    check_cnt("R4 drained", 0, 0);

    // R10 pops on an empty queue
    @(negedge clk);
    stat_pop = 1'b1; data_pop = 1'b1;
    @(negedge clk);
    stat_pop = 1'b0; data_pop = 1'b0;
    check_cnt("R10 empty pop", 0, 0);
    send_frame(1, 32'd3, 1'b1, 8'hC0);
    check_cnt("R10 after empty pop", 1, 1);
    drain_frame("R10 frame");

    // R7 data overflow mid-frame drops the frame, earlier frame intact
    af_thresh = 16'hFFFF;
    send_frame(10, 32'd40, 1'b1, 8'hC3);
    send_frame(8, 32'd30, 1'b0, 8'hD4);
    check_cnt("R7 overflow dropped", 1, 10);
    check(irq_data_full == 1'b1, "R7 data flag", 32'(irq_data_full), 1);
    check(irq_stat_full == 1'b0, "R8 no status flag", 32'(irq_stat_full), 0);

    // R11 next frame accepted
    send_frame(2, 32'h0010_0007, 1'b1, 8'hE5);
    check_cnt("R11 after drop", 2, 12);
    drain_frame("R7 frame C");
    drain_frame("R11 frame E");

    // R8 status FIFO full
    for (int f = 0; f < 4; f++) send_frame(1, 32'd4, 1'b1, 8'(f));
    check_cnt("R8 four frames", 4, 4);
    send_frame(1, 32'd4, 1'b0, 8'hF9);
    check_cnt("R8 fifth dropped", 4, 4);
    check(irq_stat_full == 1'b1, "R8 status flag", 32'(irq_stat_full), 1);
    check(irq_data_full == 1'b1, "R7 flag sticky", 32'(irq_data_full), 1);

    // R9 flush with a beat arriving at the same time
    @(negedge clk);
    flush = 1'b1; wr_valid = 1'b1; wr_last = 1'b1; wr_data = 32'hDEAD; wr_status = 32'd4;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    @(negedge clk);
    flush = 1'b0;
    exp_stat.delete();
    exp_data.delete();
    check_cnt("R9 flushed", 0, 0);
    check({irq_stat_full, irq_data_full} == 2'b0, "R9 flags cleared",
          32'({irq_stat_full, irq_data_full}), 0);
    send_frame(3, 32'd12, 1'b1, 8'h77);
    check_cnt("R9 after flush", 1, 3);
    drain_frame("R9 frame F");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule